// File: doc/BRIEF.md
# Auto-Zero Trigger Sequencer

This block decides when a low-frequency data receiver should run an auto-zero (AZ) cycle, and it drives the AZ control line. While the receiver takes in data, it counts the rising and falling edges of the demodulated data input. When the count reaches a programmed value, it starts an AZ cycle. Depending on the selected policy, the start can happen at once, can wait for a given data level, or can follow a count that is varied at random by one edge either way.

An AZ cycle has two phases. The first is a pulse whose length is a programmable number of ticks. The second is a release tail that keeps the control line high for a few more ticks. A tick is one pulse of a 250 kHz clock enable, which is half a period of the 125 kHz reference. The pulse length and release code are captured when the cycle starts, so a change during a cycle does not affect it. A busy output covers the whole span from the count being reached to the end of the release tail.

Top module: `az_trigger_seq`

## Requirements
- R1: During and right after a synchronous reset, `az_ctrl` and `busy` are 0 and the edge count is zero.
- R2: Rising and falling edges of `data_in` are both counted, each detected on the clock and counted only while idle with `rx_data_mode` high. In policy 00 (`trig_mode`=2'b00), `az_ctrl` rises at the second clock edge after the edge that completes the count.
- R3: An `edge_count` of 0 behaves as 1.
- R4: In policy 10 (`trig_mode`=2'b10), once the count is reached the block holds `busy`=1 and `az_ctrl`=0 until `data_in` is low at a clock edge. `az_ctrl` rises after that edge.
- R5: In policy 11 (`trig_mode`=2'b11), the block waits in the same way for `data_in` to be high.
- R6: In policy 01 (`trig_mode`=2'b01), the edges needed for each cycle are `edge_count` plus an offset of -1, 0 or +1. A new offset is picked at each AZ start, and the result is never less than 1. Over many cycles more than one offset occurs.
- R7: While `rx_data_mode` is 0, edges are not counted and no cycle starts. A pending wait for a data level is abandoned and `busy` returns to 0.
- R8: The pulse phase lasts `pulse_len` ticks. A value of 0 gives 1 tick.
- R9: The release tail lasts 0 ticks for `rel_code` 2'b00 and 2'b01, 1 tick for 2'b10, and 3 ticks for 2'b11.
- R10: The edge count clears when an AZ cycle starts. Edges during the pulse or the release tail are not counted.
- R11: `az_ctrl` is high for the pulse plus the release tail. `busy` is high from the count being reached until the tail ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | 250 kHz tick enable, one clock wide |
| rx_data_mode | input | 1 | High while the receiver is in data-receive mode |
| data_in | input | 1 | Demodulated data |
| edge_count | input | CNT_W | Programmed number of edges per AZ cycle |
| trig_mode | input | 2 | Trigger policy: 00 count, 01 jittered count, 10 wait low, 11 wait high |
| rel_code | input | 2 | Release tail code |
| pulse_len | input | PW | Pulse phase length in ticks |
| az_ctrl | output | 1 | AZ control line |
| busy | output | 1 | Cycle pending or running |

## Verification
The risky overlap is a data edge that arrives in the same clock edge where an AZ cycle starts or ends. That edge must not be counted, because the count is cleared at the start and counting only resumes once the block is back in idle. The bench provokes this by toggling `data_in` on every cycle of a pulse and at the moment the pulse ends. It then checks that the next cycle still needs the full programmed number of fresh edges. A second overlap is the level wait, where the wanted data level appears in the same cycle that `rx_data_mode` falls. A cycle-level reference model in the bench judges both overlaps, and random patterns that toggle data, ticks and receive mode together also exercise them.

// File: rtl/az_seq_pkg.sv
package az_seq_pkg;

    typedef enum logic [1:0] {
        TRIG_COUNT  = 2'b00,
        TRIG_JITTER = 2'b01,
        TRIG_LOW    = 2'b10,
        TRIG_HIGH   = 2'b11
    } trig_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_WAIT  = 2'b01,
        ST_PULSE = 2'b10,
        ST_TAIL  = 2'b11
    } az_state_e;

    localparam int PULSE_W_DEF = 4;
    localparam int CNT_W_DEF   = 8;
    localparam int LFSR_W_DEF  = 8;

    // release tail length in 250 kHz ticks (half periods of 125 kHz)
    function automatic logic [1:0] tail_ticks(input logic [1:0] code);
        case (code)
            2'b10:   return 2'd1;
            2'b11:   return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    // two random bits to an offset in {-1,0,+1}; the fourth code folds to 0
    function automatic logic signed [1:0] fold_offset(input logic [1:0] bits);
        case (bits)
            2'b00:   return -2'sd1;
            2'b10:   return 2'sd1;
            default: return 2'sd0;
        endcase
    endfunction

endpackage

// File: rtl/az_edge_counter.sv
module az_edge_counter #(
    parameter int CNT_W = az_seq_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             data_in,
    input  logic             count_en,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    logic data_q;
    logic edge_seen;

    assign edge_seen = data_in ^ data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= 1'b0;
            cnt    <= '0;
        end else begin
            data_q <= data_in;
            if (clr)
                cnt <= '0;
            else if (count_en && edge_seen && (cnt != '1))
                cnt <= cnt + 1'b1;
        end
    end

    AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0)); // R10

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
        (!clr && !count_en) |=> $stable(cnt)); // R7

endmodule

// File: rtl/az_jitter_lfsr.sv
module az_jitter_lfsr #(
    parameter int              LFSR_W = az_seq_pkg::LFSR_W_DEF,
    parameter logic [LFSR_W-1:0] TAPS = 8'hB8,
    parameter logic [LFSR_W-1:0] SEED = 8'h5A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pick,
    output logic signed [1:0] ofs
);
    import az_seq_pkg::*;

    logic [LFSR_W-1:0] lfsr;
    logic              fb;

    assign fb = ^(lfsr & TAPS);

    always_ff @(posedge clk) begin
        if (rst) begin
            lfsr <= SEED;
            ofs  <= 2'sd0;
        end else begin
            lfsr <= {lfsr[LFSR_W-2:0], fb};
            if (pick)
                ofs <= fold_offset(lfsr[1:0]);
        end
    end

    AST_OFS_RANGE: assert property (@(posedge clk) disable iff (rst)
        ofs != 2'sb10); // R6

    AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (rst)
        lfsr != '0); // R6

endmodule

// File: rtl/az_tick_timer.sv
module az_tick_timer #(
    parameter int W = az_seq_pkg::PULSE_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt;

    assign done = run && tick && (cnt == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (run && tick)
            cnt <= cnt + 1'b1;
    end

    AST_TMR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt < limit)); // R8

endmodule

// File: rtl/az_trigger_seq.sv
module az_trigger_seq #(
    parameter int CNT_W  = az_seq_pkg::CNT_W_DEF,
    parameter int PW     = az_seq_pkg::PULSE_W_DEF,
    parameter int LFSR_W = az_seq_pkg::LFSR_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             rx_data_mode,
    input  logic             data_in,
    input  logic [CNT_W-1:0] edge_count,
    input  logic [1:0]       trig_mode,
    input  logic [1:0]       rel_code,
    input  logic [PW-1:0]    pulse_len,
    output logic             az_ctrl,
    output logic             busy
);
    import az_seq_pkg::*;

    localparam int SW = CNT_W + 2;
    localparam logic signed [SW-1:0] ONE_S = SW'(1);
    localparam logic signed [SW-1:0] MAX_S = SW'((1 << CNT_W) - 1);

    typedef struct packed {
        logic [PW-1:0] len;
        logic [1:0]    tail;
    } az_cfg_t;

    az_state_e         st, st_nx;
    trig_mode_e        mode;
    az_cfg_t           cfg_q;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  target;
    logic signed [1:0] ofs, ofs_use;
    logic signed [SW-1:0] sum;
    logic reached, level_ok, armed, start;
    logic cnt_en, cnt_clr;
    logic tmr_run, tmr_clr, tmr_done;
    logic [PW-1:0] tmr_limit;

    assign mode = trig_mode_e'(trig_mode);

    // effective edge target
    always_comb begin
        ofs_use = (mode == TRIG_JITTER) ? ofs : 2'sd0;
        sum     = $signed({2'b00, edge_count}) + $signed({{CNT_W{ofs_use[1]}}, ofs_use});
        if (sum < ONE_S)
            target = CNT_W'(1);
        else if (sum > MAX_S)
            target = '1;
        else
            target = sum[CNT_W-1:0];
    end

    assign reached = (cnt >= target);

    always_comb begin
        case (mode)
            TRIG_LOW:  level_ok = !data_in;
            TRIG_HIGH: level_ok = data_in;
            default:   level_ok = 1'b1;
        endcase
    end

    assign armed   = (st == ST_IDLE) || (st == ST_WAIT);
    assign start   = rx_data_mode && level_ok &&
                     (((st == ST_IDLE) && reached) || (st == ST_WAIT));
    assign cnt_en  = (st == ST_IDLE) && rx_data_mode && !reached;
    assign cnt_clr = armed && (!rx_data_mode || start);

    always_comb begin
        st_nx = st;
        case (st)
            ST_IDLE:  if (rx_data_mode && reached) st_nx = start ? ST_PULSE : ST_WAIT;
            ST_WAIT:  if (!rx_data_mode)           st_nx = ST_IDLE;
                      else if (level_ok)           st_nx = ST_PULSE;
            ST_PULSE: if (tmr_done)                st_nx = (cfg_q.tail == 2'd0) ? ST_IDLE : ST_TAIL;
            ST_TAIL:  if (tmr_done)                st_nx = ST_IDLE;
            default:                               st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            cfg_q <= '0;
        end else begin
            st <= st_nx;
            if (start) begin
                cfg_q.len  <= (pulse_len == '0) ? PW'(1) : pulse_len;
                cfg_q.tail <= tail_ticks(rel_code);
            end
        end
    end

    assign tmr_run   = (st == ST_PULSE) || (st == ST_TAIL);
    assign tmr_clr   = (st_nx != st);
    assign tmr_limit = (st == ST_PULSE) ? cfg_q.len : PW'(cfg_q.tail);

    assign az_ctrl = tmr_run;
    assign busy    = (st != ST_IDLE);

    az_edge_counter #(.CNT_W(CNT_W)) u_edges (
        .clk      (clk),
        .rst      (rst),
        .data_in  (data_in),
        .count_en (cnt_en),
        .clr      (cnt_clr),
        .cnt      (cnt)
    );

    az_jitter_lfsr #(.LFSR_W(LFSR_W)) u_jitter (
        .clk  (clk),
        .rst  (rst),
        .pick (start),
        .ofs  (ofs)
    );

    az_tick_timer #(.W(PW)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clr   (tmr_clr),
        .run   (tmr_run),
        .tick  (tick_en),
        .limit (tmr_limit),
        .done  (tmr_done)
    );

    AST_LOW_GATE: assert property (@(posedge clk) disable iff (rst)
        ($rose(az_ctrl) && ($past(trig_mode) == 2'b10)) |-> !$past(data_in)); // R4

    AST_HIGH_GATE: assert property (@(posedge clk) disable iff (rst)
        ($rose(az_ctrl) && ($past(trig_mode) == 2'b11)) |-> $past(data_in)); // R5

    AST_RX_ONLY: assert property (@(posedge clk) disable iff (rst)
        $rose(az_ctrl) |-> $past(rx_data_mode)); // R7

    AST_CLEAR_AT_START: assert property (@(posedge clk) disable iff (rst)
        $rose(az_ctrl) |-> (cnt == '0)); // R10

endmodule

// File: tb/test_az_trigger_seq.sv
module test_az_trigger_seq;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 8;
    localparam int PW    = 4;

    logic clk = 1'b0;
    logic rst, tick_en, rx_data_mode, data_in;
    logic [CNT_W-1:0] edge_count;
    logic [1:0] trig_mode, rel_code;
    logic [PW-1:0] pulse_len;
    logic az_ctrl, busy;

    az_trigger_seq #(.CNT_W(CNT_W), .PW(PW)) i_az_trigger_seq (
        .clk(clk), .rst(rst), .tick_en(tick_en), .rx_data_mode(rx_data_mode),
        .data_in(data_in), .edge_count(edge_count), .trig_mode(trig_mode),
        .rel_code(rel_code), .pulse_len(pulse_len), .az_ctrl(az_ctrl), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  chk_en  = 1'b1;

    // reference model state: 0 idle, 1 wait, 2 pulse, 3 tail
    int m_st = 0, m_cnt = 0, m_tc = 0, m_len = 1, m_tail = 0;
    bit m_prev = 1'b0;

    function automatic int f_tail(input logic [1:0] c);
        return (c == 2'b10) ? 1 : (c == 2'b11) ? 3 : 0;
    endfunction

    function automatic int f_tgt(input int n);
        return (n < 1) ? 1 : n;
    endfunction

    function automatic bit f_lvl(input logic [1:0] m, input logic d);
        return (m == 2'b10) ? !d : (m == 2'b11) ? d : 1'b1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit e, go;
        go = 1'b0;
        if (rst) begin
            m_st = 0; m_cnt = 0; m_tc = 0; m_len = 1; m_tail = 0; m_prev = 1'b0;
        end else begin
            e = (data_in != m_prev);
            m_prev = data_in;
            case (m_st)
                0: if (!rx_data_mode) m_cnt = 0;
                   else if (m_cnt >= f_tgt(int'(edge_count))) begin
                       if (f_lvl(trig_mode, data_in)) go = 1'b1; else m_st = 1;
                   end else if (e) m_cnt++;
                1: if (!rx_data_mode) begin m_st = 0; m_cnt = 0; end
                   else if (f_lvl(trig_mode, data_in)) go = 1'b1;
                2: if (tick_en) begin
                       if (m_tc == m_len - 1) begin m_tc = 0; m_st = (m_tail == 0) ? 0 : 3; end
                       else m_tc++;
                   end
                default: if (tick_en) begin
                       if (m_tc == m_tail - 1) begin m_tc = 0; m_st = 0; end
                       else m_tc++;
                   end
            endcase
            if (go) begin
                m_st = 2; m_cnt = 0; m_tc = 0;
                m_len  = (pulse_len == 0) ? 1 : int'(pulse_len);
                m_tail = f_tail(rel_code);
            end
        end
    end

    always @(negedge clk) begin
        if (chk_en && !rst) begin
            check(az_ctrl == (m_st >= 2), "R11 model az_ctrl", int'(az_ctrl), int'(m_st >= 2));
            check(busy == (m_st != 0), "R11 model busy", int'(busy), int'(m_st != 0));
        end
    end

    task automatic nx();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; data_in = 1'b0;
        nx(); nx();
        check(az_ctrl == 1'b0 && busy == 1'b0, "R1 in reset", int'({az_ctrl, busy}), 0);
        rst = 1'b0;
        nx();
        check(az_ctrl == 1'b0 && busy == 1'b0, "R1 after reset", int'({az_ctrl, busy}), 0);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100 && busy; i++) nx();
    endtask

    // mode 00, count 1: one edge, then measure the high width of az_ctrl
    task automatic width_run(input int len, input int rc, output int w);
        trig_mode = 2'b00; edge_count = 1; pulse_len = PW'(len); rel_code = 2'(rc);
        data_in = !data_in; nx(); nx();
        w = 0;
        for (int i = 0; i < 40 && az_ctrl; i++) begin w++; nx(); end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int w;
        void'($urandom(32'd4711));
        tick_en = 1'b1; rx_data_mode = 1'b1; data_in = 1'b0;
        edge_count = 3; trig_mode = 2'b00; rel_code = 2'b10; pulse_len = 2;
        rst = 1'b1;
        nx();
        do_reset();

        // R2: three edges of both directions, start two edges after the third
        data_in = 1; nx(); data_in = 0; nx();
        check(az_ctrl == 0 && busy == 0, "R2 before count", int'(az_ctrl), 0);
        data_in = 1; nx();
        check(az_ctrl == 0, "R2 count just reached", int'(az_ctrl), 0);
        nx();
        check(az_ctrl == 1, "R2 start", int'(az_ctrl), 1);
        w = 1; nx();
        while (az_ctrl && w < 40) begin w++; nx(); end
        check(w == 3, "R9 len2 code10 width", w, 3);

        // R9 / R8: widths
        width_run(2, 0, w); check(w == 2, "R9 code00", w, 2);
        width_run(2, 1, w); check(w == 2, "R9 code01", w, 2);
        width_run(2, 3, w); check(w == 5, "R9 code11", w, 5);
        width_run(0, 0, w); check(w == 1, "R8 len0", w, 1);
        width_run(3, 0, w); check(w == 3, "R8 len3", w, 3);

        // R3: count of zero acts as one
        trig_mode = 2'b00; edge_count = 0; pulse_len = 1; rel_code = 0;
        data_in = !data_in; nx(); nx();
        check(az_ctrl == 1, "R3 count zero", int'(az_ctrl), 1);
        wait_idle();

        // R10: edges during pulse are ignored
        edge_count = 2; pulse_len = 4; rel_code = 0;
        data_in = !data_in; nx(); data_in = !data_in; nx(); nx();
        check(az_ctrl == 1, "R10 start", int'(az_ctrl), 1);
        for (int i = 0; i < 3; i++) begin data_in = !data_in; nx(); end
        data_in = !data_in; nx();
        check(busy == 0, "R10 pulse over", int'(busy), 0);
        data_in = !data_in; nx(); nx();
        check(az_ctrl == 0, "R10 only one fresh edge", int'(az_ctrl), 0);
        data_in = !data_in; nx(); nx();
        check(az_ctrl == 1, "R10 second fresh edge", int'(az_ctrl), 1);
        wait_idle();

        // R4: wait for low level
        rx_data_mode = 0; data_in = 0; nx(); rx_data_mode = 1;
        trig_mode = 2'b10; edge_count = 1; pulse_len = 1;
        data_in = 1; nx(); nx();
        check(busy == 1 && az_ctrl == 0, "R4 waiting", int'({busy, az_ctrl}), 2);
        nx(); nx();
        check(busy == 1 && az_ctrl == 0, "R4 still waiting", int'({busy, az_ctrl}), 2);
        data_in = 0; nx();
        check(az_ctrl == 1, "R4 low releases", int'(az_ctrl), 1);
        wait_idle();

        // R5: wait for high level
        rx_data_mode = 0; data_in = 1; nx(); rx_data_mode = 1;
        trig_mode = 2'b11;
        data_in = 0; nx(); nx();
        check(busy == 1 && az_ctrl == 0, "R5 waiting", int'({busy, az_ctrl}), 2);
        data_in = 1; nx();
        check(az_ctrl == 1, "R5 high releases", int'(az_ctrl), 1);
        wait_idle();

        // R7: receive mode off
        rx_data_mode = 0; trig_mode = 2'b00; edge_count = 1;
        for (int i = 0; i < 5; i++) begin
            data_in = !data_in; nx();
            check(az_ctrl == 0 && busy == 0, "R7 no count off-mode", int'({az_ctrl, busy}), 0);
        end
        rx_data_mode = 0; data_in = 1; nx(); rx_data_mode = 1; trig_mode = 2'b10;
        data_in = 0; nx(); data_in = 1; nx(); nx();
        check(busy == 1, "R7 wait entered", int'(busy), 1);
        rx_data_mode = 0; nx();
        check(busy == 0 && az_ctrl == 0, "R7 wait abandoned", int'({busy, az_ctrl}), 0);
        rx_data_mode = 1; nx();

        // random traffic, checked by the model
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 50 == 0) begin
                int mm;
                mm = $urandom % 3;
                trig_mode  = (mm == 0) ? 2'b00 : (mm == 1) ? 2'b10 : 2'b11;
                edge_count = CNT_W'($urandom % 5);
                pulse_len  = PW'($urandom % 4);
                rel_code   = 2'($urandom % 4);
            end
            if ($urandom % 3 == 0) data_in = !data_in;
            tick_en = ($urandom % 4) != 0;
            if ($urandom % 40 == 0) rx_data_mode = !rx_data_mode;
            nx();
        end

        // R6: jittered count
        chk_en = 1'b0; tick_en = 1; rx_data_mode = 1;
        trig_mode = 2'b01; pulse_len = 1; rel_code = 0;
        for (int n = 3; n >= 1; n -= 2) begin
            int low, seen, mn, mx;
            bit started;
            edge_count = CNT_W'(n);
            do_reset();
            low = 0; seen = 0; mn = 99; mx = -1; started = 0;
            for (int i = 0; i < 600 && seen < 30; i++) begin
                data_in = !data_in; nx();
                if (!busy) low++;
                else begin
                    if (started) begin
                        int t;
                        t = low - 1;
                        check(t >= f_tgt(n - 1) && t <= n + 1, "R6 edges per cycle", t, n);
                        if (t < mn) mn = t;
                        if (t > mx) mx = t;
                        seen++;
                    end
                    started = 1; low = 0;
                end
            end
            check(seen == 30, "R6 cycles seen", seen, 30);
            check(mx > mn, "R6 offset varies", mx - mn, 1);
        end

        rst = 1'b1; nx(); nx(); rst = 1'b0; chk_en = 1'b1; nx();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule